// File: doc/BRIEF.md
# Programmable Logic Macrocell

This block is one output cell of a small sum-of-products logic fabric. A vector of array inputs, plus the cell's own pin feedback, feeds eight product terms whose literals are picked by configuration bits. Four of the terms are ORed to form the data value. The other four terms each own one control of the cell: an immediate set, an immediate reset, an emulated clock and a drive enable. The cell drives one pad through separate data and enable outputs and reports the level seen on that pad.

The cell does not use a mode bit. When both the set term and the reset term have no literals selected, they are true for every input, and the cell passes the data value straight to the pad. In every other case the data value is held in a D-type state bit. That bit loads when the clock term rises, where the rise is detected on the free-running system clock.

The state bit can also be preloaded from the pad level through an active-low load input, without waiting for a clock. A configuration bit picks active-high or active-low output in both modes. The power-on reset clears the state bit. The pad level goes back into the term array, so a chain of such cells can build a state machine.

Top module: `plmc_cell`

## Requirements
- R1: Literal j (j < N_IN) is `arr_in[j]` and literal N_IN is the feedback literal. Product term k reads `cfg_terms[2*NL*k + j]`, which requires literal j to be 1, and `cfg_terms[2*NL*k + NL + j]`, which requires it to be 0 (NL = N_IN+1). A term with no bits set is true. A term that requires both values of one literal is false.
- R2: The data value is the OR of terms 0, 1, 2 and 3.
- R3: When every configuration bit of term 4 (set) and term 5 (reset) is 0, the cell is in pass-through mode. The core value then equals the data value in the same cycle.
- R4: In stored mode the state bit takes the data value at the system clock edge that ends a cycle in which term 6 is 1 and was 0 in the previous cycle. If term 6 stays high, nothing further is loaded. Right after reset, term 6 counts as previously high.
- R5: In stored mode, term 5 forces the core value to 0 and term 4 forces it to 1, both in the same cycle, and the forced value is stored at the edge. When both terms are true, term 5 wins.
- R6: When `load_n` is 0 and neither term 4 nor term 5 is true, the state bit loads `pad_in` (active-high) or `~pad_in` (active-low) at the edge, so the pad then shows the level that was applied. This takes priority over a clock rise.
- R7: `pad_out` equals the core value when `cfg_act_high` is 1 and its inverse when it is 0.
- R8: `pad_oe` is 1 only when term 7 is true and `ext_en_n` is 0.
- R9: After reset the state bit is 0, so an active-low cell drives 1 and an active-high cell drives 0. The feedback literal also starts at 0.
- R10: `fb_out` is `pad_out` while `pad_oe` is 1 and `pad_in` otherwise. The feedback literal is `fb_out` as sampled at the previous system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| arr_in | input | N_IN | Array inputs from pins and other cells |
| cfg_terms | input | 16*(N_IN+1) | Literal selection for the eight product terms |
| cfg_act_high | input | 1 | 1: active-high output, 0: active-low |
| ext_en_n | input | 1 | Active-low external drive enable |
| load_n | input | 1 | Active-low preload strobe |
| pad_in | input | 1 | Level observed on the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Resolved pad level |

## Verification
The preload strobe and a clock-term rise can land in the same system cycle. Either one, in that cycle, can also coincide with a set or reset term. The bench provokes this by holding `load_n` low while the clock term rises with a data value opposite to `pad_in`, and separately by raising the reset term together with the preload. The stored value is then judged one cycle later on `pad_out`. The two possible outcomes differ, so the value shows which action took priority.

// File: rtl/plmc_pkg.sv
package plmc_pkg;
   localparam int unsigned TERMS      = 8;
   localparam int unsigned DATA_TERMS = 4;
   localparam int unsigned IDX_SET    = 4;
   localparam int unsigned IDX_RST    = 5;
   localparam int unsigned IDX_CLK    = 6;
   localparam int unsigned IDX_OE     = 7;

   typedef struct packed {
      logic set;
      logic rst;
      logic clk;
      logic oe;
      logic data;
   } ctl_s;
endpackage

// File: rtl/plmc_and_term.sv
module plmc_and_term #(
   parameter int unsigned NL = 5
) (
   input  logic [NL-1:0] lits,
   input  logic [NL-1:0] need_one,
   input  logic [NL-1:0] need_zero,
   output logic          term
);
   if (NL < 2) begin : g_bad_nl
      $error("plmc_and_term: NL must be at least 2");
   end

   logic [NL-1:0] lit_ok;

   for (genvar j = 0; j < NL; j++) begin : g_lit
      assign lit_ok[j] = ~(need_one[j] & ~lits[j]) & ~(need_zero[j] & lits[j]);
   end

   assign term = &lit_ok;
endmodule

// File: rtl/plmc_term_array.sv
module plmc_term_array #(
   parameter int unsigned NL = 5
) (
   input  logic [NL-1:0]                        lits,
   input  logic [plmc_pkg::TERMS*2*NL-1:0]      cfg,
   output logic [plmc_pkg::TERMS-1:0]           terms,
   output plmc_pkg::ctl_s                       ctl,
   output logic                                 pass_mode
);
   import plmc_pkg::*;

   localparam int unsigned STRIDE = 2 * NL;

   for (genvar k = 0; k < TERMS; k++) begin : g_term
      plmc_and_term #(.NL(NL)) u_term (
         .lits      (lits),
         .need_one  (cfg[k*STRIDE +: NL]),
         .need_zero (cfg[k*STRIDE + NL +: NL]),
         .term      (terms[k])
      );
   end

   assign ctl.data = |terms[DATA_TERMS-1:0];
   assign ctl.set  = terms[IDX_SET];
   assign ctl.rst  = terms[IDX_RST];
   assign ctl.clk  = terms[IDX_CLK];
   assign ctl.oe   = terms[IDX_OE];

   // pass-through when both control terms select nothing (true for all inputs)
   assign pass_mode = ~(|cfg[IDX_SET*STRIDE +: STRIDE]) & ~(|cfg[IDX_RST*STRIDE +: STRIDE]);
endmodule

// File: rtl/plmc_state_reg.sv
module plmc_state_reg #(
   parameter bit HIST_INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_t,
   input  logic rst_t,
   input  logic clk_t,
   input  logic d,
   input  logic load_n,
   input  logic pad_in,
   input  logic act_high,
   output logic q_store,
   output logic q_vis,
   output logic edge_seen
);
   logic hist_q;

   assign edge_seen = clk_t & ~hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_store <= 1'b0;
         hist_q  <= HIST_INIT;
      end else begin
         hist_q <= clk_t;
         if (rst_t)
            q_store <= 1'b0;
         else if (set_t)
            q_store <= 1'b1;
         else if (!load_n)
            q_store <= pad_in ^ ~act_high;
         else if (edge_seen)
            q_store <= d;
      end
   end

   // set and reset override the stored bit without waiting for an edge
   always_comb begin
      if (rst_t)
         q_vis = 1'b0;
      else if (set_t)
         q_vis = 1'b1;
      else
         q_vis = q_store;
   end
endmodule

// File: rtl/plmc_out_stage.sv
module plmc_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic pass_mode,
   input  logic d,
   input  logic q_vis,
   input  logic act_high,
   input  logic oe_t,
   input  logic ext_en_n,
   input  logic pad_in,
   output logic core,
   output logic pad_out,
   output logic pad_oe,
   output logic fb_out,
   output logic fb_lit
);
   assign core    = pass_mode ? d : q_vis;
   assign pad_out = core ^ ~act_high;
   assign pad_oe  = oe_t & ~ext_en_n;
   assign fb_out  = pad_oe ? pad_out : pad_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fb_lit <= 1'b0;
      else
         fb_lit <= fb_out;
   end
endmodule

// File: rtl/plmc_cell.sv
module plmc_cell #(
   parameter int unsigned N_IN = 4,
   parameter bit          HIST_INIT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_IN-1:0]          arr_in,
   input  logic [16*(N_IN+1)-1:0]   cfg_terms,
   input  logic                     cfg_act_high,
   input  logic                     ext_en_n,
   input  logic                     load_n,
   input  logic                     pad_in,
   output logic                     pad_out,
   output logic                     pad_oe,
   output logic                     fb_out
);
   import plmc_pkg::*;

   localparam int unsigned NL = N_IN + 1;

   if (N_IN < 1 || N_IN > 63) begin : g_bad_n_in
      $error("plmc_cell: N_IN must lie in 1..63");
   end
   if (TERMS * 2 * NL != 16 * NL) begin : g_bad_terms
      $error("plmc_cell: configuration width mismatch");
   end

   logic [NL-1:0]    lits;
   logic [TERMS-1:0] t_vec;
   ctl_s             ctl;
   logic             pass_mode;
   logic             q_store;
   logic             q_vis;
   logic             edge_seen;
   logic             core_v;
   logic             fb_lit;

   assign lits = {fb_lit, arr_in};

   plmc_term_array #(.NL(NL)) u_array (
      .lits      (lits),
      .cfg       (cfg_terms),
      .terms     (t_vec),
      .ctl       (ctl),
      .pass_mode (pass_mode)
   );

   plmc_state_reg #(.HIST_INIT(HIST_INIT)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_t     (ctl.set),
      .rst_t     (ctl.rst),
      .clk_t     (ctl.clk),
      .d         (ctl.data),
      .load_n    (load_n),
      .pad_in    (pad_in),
      .act_high  (cfg_act_high),
      .q_store   (q_store),
      .q_vis     (q_vis),
      .edge_seen (edge_seen)
   );

   plmc_out_stage u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .pass_mode (pass_mode),
      .d         (ctl.data),
      .q_vis     (q_vis),
      .act_high  (cfg_act_high),
      .oe_t      (ctl.oe),
      .ext_en_n  (ext_en_n),
      .pad_in    (pad_in),
      .core      (core_v),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .fb_out    (fb_out),
      .fb_lit    (fb_lit)
   );
endmodule

// File: rtl/plmc_cell_chk.sv
module plmc_cell_chk (
   input logic clk,
   input logic rst_n,
   input logic pass_mode,
   input logic t_set,
   input logic t_rst,
   input logic d,
   input logic edge_seen,
   input logic q_store,
   input logic load_n,
   input logic pad_in,
   input logic act_high,
   input logic ext_en_n,
   input logic pad_out,
   input logic pad_oe,
   input logic fb_out,
   input logic fb_lit
);
   assert_pass_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pass_mode |-> (pad_out == (d ^ ~act_high)));

   assert_edge_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_mode && !t_rst && !t_set && load_n && edge_seen) |=> (q_store == $past(d)));

   assert_reset_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_mode && t_rst) |-> (pad_out == ~act_high));

   assert_set_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass_mode && t_set && !t_rst) |-> (pad_out == act_high));

   assert_preload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!t_rst && !t_set && !load_n) |=> (q_store == $past(pad_in ^ ~act_high)));

   assert_pin_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_en_n |-> !pad_oe);

   assert_fb_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fb_lit == $past(fb_out)));
endmodule

bind plmc_cell plmc_cell_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pass_mode (pass_mode),
   .t_set     (ctl.set),
   .t_rst     (ctl.rst),
   .d         (ctl.data),
   .edge_seen (edge_seen),
   .q_store   (q_store),
   .load_n    (load_n),
   .pad_in    (pad_in),
   .act_high  (cfg_act_high),
   .ext_en_n  (ext_en_n),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .fb_out    (fb_out),
   .fb_lit    (fb_lit)
);

// File: tb/plmc_cell_bench.sv
module plmc_cell_bench;
   localparam int N_IN = 4;
   localparam int NL   = N_IN + 1;
   localparam int CFGW = 16 * NL;

   function automatic logic [CFGW-1:0] tm(input int k, input logic [NL-1:0] one_m,
                                          input logic [NL-1:0] zero_m);
      logic [CFGW-1:0] v;
      v = '0;
      v[k*2*NL +: NL]      = one_m;
      v[k*2*NL + NL +: NL] = zero_m;
      return v;
   endfunction

   // terms 1..3 made false by requiring literal 0 both ways
   localparam logic [CFGW-1:0] KILL123 = tm(1, 5'b00001, 5'b00001) | tm(2, 5'b00001, 5'b00001)
                                       | tm(3, 5'b00001, 5'b00001);
   localparam logic [CFGW-1:0] REG2 = tm(0, 5'b00001, 5'b0) | KILL123 | tm(4, 5'b00010, 5'b0)
                                    | tm(5, 5'b01000, 5'b0) | tm(6, 5'b00100, 5'b0);
   localparam logic [CFGW-1:0] TOG  = tm(0, 5'b0, 5'b10000) | KILL123 | tm(4, 5'b00001, 5'b00001)
                                    | tm(5, 5'b00001, 5'b00001) | tm(6, 5'b00100, 5'b0);
   localparam logic [CFGW-1:0] FBC  = tm(0, 5'b10000, 5'b0) | KILL123;

   // pass-through table: config, inputs, polarity, enable pin, expected pad and enable
   localparam int NTV = 7;
   localparam logic [CFGW-1:0] TV_CFG [NTV] = '{
      tm(0, 5'b00011, 5'b0) | KILL123,
      tm(0, 5'b00011, 5'b0) | KILL123,
      tm(0, 5'b00011, 5'b0) | KILL123,
      tm(0, 5'b0, 5'b00100) | KILL123,
      tm(0, 5'b01000, 5'b0) | tm(1, 5'b00010, 5'b0) | tm(2, 5'b00001, 5'b00001) | tm(3, 5'b00001, 5'b00001),
      '0,
      tm(0, 5'b00011, 5'b0) | KILL123 | tm(7, 5'b00001, 5'b00001)};
   localparam logic [N_IN-1:0] TV_ARR [NTV] = '{4'b0011, 4'b0001, 4'b0011, 4'b0100, 4'b0010, 4'b1111, 4'b0011};
   localparam logic TV_ACT [NTV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
   localparam logic TV_ENN [NTV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
   localparam logic TV_OUT [NTV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam logic TV_OE  [NTV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N_IN-1:0] arr_in = '0;
   logic [CFGW-1:0] cfg_terms = '0;
   logic            cfg_act_high = 1'b1;
   logic            ext_en_n = 1'b0;
   logic            load_n = 1'b1;
   logic            pad_in = 1'b0;
   logic            pad_out, pad_oe, fb_out;

   int checks = 0;
   int failures = 0;

   logic ref_q, ref_hist, ref_fb;

   plmc_cell #(.N_IN(N_IN)) u_plmc_cell (
      .clk(clk), .rst_n(rst_n), .arr_in(arr_in), .cfg_terms(cfg_terms),
      .cfg_act_high(cfg_act_high), .ext_en_n(ext_en_n), .load_n(load_n),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out));

   always #4 clk = ~clk;

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog: run did not finish, actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic ref_term(input logic [CFGW-1:0] c, input int k, input logic [NL-1:0] l);
      logic r;
      r = 1'b1;
      for (int j = 0; j < NL; j++) begin
         if (c[k*2*NL + j] && !l[j]) r = 1'b0;
         if (c[k*2*NL + NL + j] && l[j]) r = 1'b0;
      end
      return r;
   endfunction

   // one system cycle: compare against the reference model, then advance it
   task automatic cycle();
      logic [NL-1:0] l;
      logic [7:0] t;
      logic d, pass, core, eo, eoe, efb;
      #1;
      l = {ref_fb, arr_in};
      for (int k = 0; k < 8; k++) t[k] = ref_term(cfg_terms, k, l);
      d    = |t[3:0];
      pass = (cfg_terms[4*2*NL +: 2*NL] == '0) && (cfg_terms[5*2*NL +: 2*NL] == '0);
      core = pass ? d : (t[5] ? 1'b0 : (t[4] ? 1'b1 : ref_q));
      eo   = cfg_act_high ? core : ~core;
      eoe  = t[7] & ~ext_en_n;
      efb  = eoe ? eo : pad_in;
      check("REF R1 R2 R4 R5 R7", pad_out, eo);
      check("REF R8", pad_oe, eoe);
      check("REF R10", fb_out, efb);
      if (t[5]) ref_q = 1'b0;
      else if (t[4]) ref_q = 1'b1;
      else if (!load_n) ref_q = pad_in ^ ~cfg_act_high;
      else if (t[6] && !ref_hist) ref_q = d;
      ref_hist = t[6];
      ref_fb   = efb;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic step(input string tag, input logic exp_out);
      #1;
      check(tag, pad_out, exp_out);
      cycle();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      ref_q = 1'b0; ref_hist = 1'b1; ref_fb = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();

      // table walk, pass-through mode (R1 R2 R3 R7 R8)
      for (int i = 0; i < NTV; i++) begin
         cfg_terms = TV_CFG[i]; arr_in = TV_ARR[i]; cfg_act_high = TV_ACT[i];
         ext_en_n = TV_ENN[i]; load_n = 1'b1; pad_in = 1'b0;
         #1;
         check("R3 table pad", pad_out, TV_OUT[i]);
         check("R8 table enable", pad_oe, TV_OE[i]);
         cycle();
      end

      // R9 reset state in stored mode
      cfg_terms = REG2; ext_en_n = 1'b0;
      do_reset();
      arr_in = 4'b0000; cfg_act_high = 1'b1;
      #1; check("R9 enable after reset", pad_oe, 1'b1);
      step("R9 active-high reset level", 1'b0);
      cfg_act_high = 1'b0; step("R9 active-low reset level", 1'b1);
      cfg_act_high = 1'b1;

      // R4 edge load
      arr_in = 4'b0001; step("R4 no edge", 1'b0);
      arr_in = 4'b0101; step("R4 before edge", 1'b0);
      arr_in = 4'b0001; step("R4 loaded", 1'b1);
      arr_in = 4'b0100; step("R4 rise with d=0", 1'b1);
      arr_in = 4'b0101; step("R4 reload zero", 1'b0);
      arr_in = 4'b0000; step("R4 held high no reload", 1'b0);

      // R5 immediate set/reset and priority
      arr_in = 4'b0010; step("R5 immediate set", 1'b1);
      arr_in = 4'b0000; step("R5 set stored", 1'b1);
      arr_in = 4'b1000; step("R5 immediate reset", 1'b0);
      arr_in = 4'b1010; step("R5 reset over set", 1'b0);
      arr_in = 4'b0000; step("R5 reset stored", 1'b0);

      // R6 preload, priority against clock and reset
      load_n = 1'b0; pad_in = 1'b1; step("R6 preload cycle", 1'b0);
      load_n = 1'b1; pad_in = 1'b0; step("R6 preload loaded", 1'b1);
      load_n = 1'b0; arr_in = 4'b0101; step("R6 preload with clock", 1'b1);
      load_n = 1'b1; arr_in = 4'b0000; step("R6 preload beats clock", 1'b0);
      cfg_act_high = 1'b0; load_n = 1'b0; pad_in = 1'b0; step("R6 active-low before", 1'b1);
      load_n = 1'b1; step("R6 active-low pin level", 1'b0);
      cfg_act_high = 1'b1;
      #1; check("R6 state is one", pad_out, 1'b1);
      load_n = 1'b0; pad_in = 1'b1; arr_in = 4'b1000; step("R6 reset during preload", 1'b0);
      load_n = 1'b1; arr_in = 4'b0000; step("R6 reset beats preload", 1'b0);

      // R8 enable gating
      ext_en_n = 1'b1; pad_in = 1'b1;
      #1; check("R8 pin disables", pad_oe, 1'b0); check("R10 fb from pad_in", fb_out, 1'b1);
      cycle();
      ext_en_n = 1'b0; cfg_terms = REG2 | tm(7, 5'b00001, 5'b00001);
      #1; check("R8 term disables", pad_oe, 1'b0);
      cycle();
      cfg_terms = REG2; pad_in = 1'b0;
      #1; check("R8 enabled", pad_oe, 1'b1);
      cycle();

      // R10 feedback-driven toggle
      cfg_terms = TOG; arr_in = 4'b0000; step("R10 idle", 1'b0);
      arr_in = 4'b0100; step("R10 rise one", 1'b0);
      arr_in = 4'b0000; step("R10 toggled high", 1'b1);
      step("R10 settle", 1'b1);
      arr_in = 4'b0100; step("R10 rise two", 1'b1);
      arr_in = 4'b0000; step("R10 toggled low", 1'b0);

      // R10 feedback from pad_in in pass-through mode
      cfg_terms = FBC; ext_en_n = 1'b1; pad_in = 1'b1;
      #1; check("R10 fb follows pad_in", fb_out, 1'b1);
      cycle();
      ext_en_n = 1'b0; pad_in = 1'b0;
      step("R10 delayed literal", 1'b1);

      // randomized configurations against the reference model
      for (int blk = 0; blk < 12; blk++) begin
         logic [95:0] r;
         r = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
           & {$urandom, $urandom, $urandom};
         cfg_terms = r[CFGW-1:0];
         if (blk % 3 == 0) cfg_terms[4*2*NL +: 4*NL] = '0;
         for (int c = 0; c < 40; c++) begin
            arr_in = N_IN'($urandom);
            cfg_act_high = 1'($urandom);
            ext_en_n = ($urandom % 4 == 0);
            load_n = ($urandom % 8 != 0);
            pad_in = 1'($urandom);
            cycle();
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule